// File: doc/BRIEF.md
# Bus-Cycle Break Detector

This block sits beside a system bus and inspects every cycle the bus presents. When a cycle falls inside a programmed address window and carries the programmed attributes, it raises a break interrupt request toward the processor. The attributes are the bus master (CPU or DMA), the access kind (instruction fetch or data) and the direction (read or write). Software sets up three registers over a simple write-only port: a target address, an address bit mask, and a condition word. The condition word holds one enable bit and three two-bit attribute selectors.

A match sets a sticky pending flag. The request toward the processor carries the fixed top priority level of 15, so it is presented only while the processor's 4-bit interrupt mask is below that level. If the mask sits at 15, for example inside a non-maskable interrupt handler, the request stays pending. It is presented as soon as software lowers the mask. The pending flag clears only when the processor side returns an acknowledge pulse.

Top module: `brk_cycle_watch`

## Requirements
- R1: After reset the address, mask and condition registers are all zero, `brk_pend` and `brk_req` are 0, and no bus cycle sets a break until the condition word is programmed.
- R2: A bus address matches when every address bit whose mask bit is 0 equals the matching target bit; address bits whose mask bit is 1 are ignored.
- R3: The master selector (condition bits [1:0]) accepts, for code 01, only CPU cycles (`bus_dma`=0); for code 10, only DMA cycles (`bus_dma`=1); and for code 11, either kind.
- R4: The access-kind selector (condition bits [3:2]) accepts, for code 01, only instruction fetches (`bus_data`=0); for code 10, only data accesses (`bus_data`=1); and for code 11, both.
- R5: The direction selector (condition bits [5:4]) accepts, for code 01, only reads (`bus_wr`=0); for code 10, only writes (`bus_wr`=1); and for code 11, both.
- R6: If any of the three selectors holds 00, no break is raised, even when every other condition matches.
- R7: With the enable bit (condition bit 6) at 0, no break is raised.
- R8: A matching cycle with `bus_vld` high sets `brk_pend` at the next clock edge. The flag then stays set until an edge at which `irq_ack` is high and no new match occurs.
- R9: `brk_req` equals `brk_pend` while `cpu_imask` is 14 or lower, and it is 0 while `cpu_imask` is 15. A request held at mask 15 appears as soon as the mask drops to 14 or below.
- R10: A register write takes effect for bus cycles after its clock edge. A bus cycle in the same cycle as the write is compared against the old register values.
- R11: When `bus_vld` is low, no comparison happens and `brk_pend` does not change except through `irq_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 target address, 1 address mask, 2 condition word |
| cfg_wdata | input | ADDR_W | Write data (condition word uses bits [6:0]) |
| bus_vld | input | 1 | One-cycle strobe marking a bus cycle |
| bus_addr | input | ADDR_W | Bus cycle address |
| bus_dma | input | 1 | 1 = DMA master, 0 = CPU |
| bus_data | input | 1 | 1 = data access, 0 = instruction fetch |
| bus_wr | input | 1 | 1 = write, 0 = read |
| cpu_imask | input | MASK_W | Processor interrupt mask level |
| irq_ack | input | 1 | Acceptance handshake, clears the pending flag |
| brk_pend | output | 1 | Sticky break pending flag |
| brk_req | output | 1 | Break request presented at level 15 |

## Verification
The hardest case to reach is a request held back at mask level 15 and then released. To reach it, the bench raises a match while `cpu_imask` is 15 and idles several cycles with no acknowledge. It confirms that `brk_pend` stays high while `brk_req` stays low, then lowers the mask to 14 and looks for the request. A second hard case is a register write that lands on the same edge as a bus cycle. The bench drives both in one cycle, expects the old target to match, and then expects the new target to take over on the next cycle.

// File: rtl/brk_pkg.sv
package brk_pkg;

  localparam int COND_W = 7;

  typedef enum logic [1:0] {
    REG_TGT  = 2'd0,
    REG_MASK = 2'd1,
    REG_COND = 2'd2
  } brk_reg_e;

  // condition word: enable, direction, access kind, master
  typedef struct packed {
    logic       en;
    logic [1:0] dir_sel;
    logic [1:0] kind_sel;
    logic [1:0] mst_sel;
  } brk_cond_t;

  // selector code: bit0 admits the first option, bit1 the second
  function automatic logic sel_ok(input logic [1:0] sel, input logic alt);
    return alt ? sel[1] : sel[0];
  endfunction

endpackage

// File: rtl/brk_cfg_regs.sv
module brk_cfg_regs
  import brk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] tgt_q,
  output logic [ADDR_W-1:0] amask_q,
  output brk_cond_t         cond_q
);

  logic tgt_en, mask_en, cond_en;
  logic [ADDR_W-1:0] tgt_d, amask_d;
  brk_cond_t cond_d;

  always_comb begin
    tgt_en  = cfg_we && (brk_reg_e'(cfg_sel) == REG_TGT);
    mask_en = cfg_we && (brk_reg_e'(cfg_sel) == REG_MASK);
    cond_en = cfg_we && (brk_reg_e'(cfg_sel) == REG_COND);
    tgt_d   = cfg_wdata;
    amask_d = cfg_wdata;
    cond_d  = brk_cond_t'(cfg_wdata[COND_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q   <= '0;
      amask_q <= '0;
      cond_q  <= '0;
    end else begin
      if (tgt_en)  tgt_q   <= tgt_d;
      if (mask_en) amask_q <= amask_d;
      if (cond_en) cond_q  <= cond_d;
    end
  end

endmodule

// File: rtl/brk_cycle_match.sv
module brk_cycle_match
  import brk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              bus_vld,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_dma,
  input  logic              bus_data,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] tgt,
  input  logic [ADDR_W-1:0] amask,
  input  brk_cond_t         cond,
  output logic              cyc_hit
);

  localparam int NFLD = 3;

  logic [NFLD-1:0][1:0] sels;
  logic [NFLD-1:0]      attr;
  logic [NFLD-1:0]      fld_ok;
  logic                 addr_ok;

  assign sels = {cond.dir_sel, cond.kind_sel, cond.mst_sel};
  assign attr = {bus_wr, bus_data, bus_dma};

  for (genvar i = 0; i < NFLD; i++) begin : g_fld
    assign fld_ok[i] = sel_ok(sels[i], attr[i]);
  end

  always_comb begin
    addr_ok = (((bus_addr ^ tgt) & ~amask) == '0);
    cyc_hit = bus_vld && cond.en && addr_ok && (&fld_ok);
  end

endmodule

// File: rtl/brk_accept.sv
module brk_accept #(
  parameter int MASK_W    = 4,
  parameter int BRK_LEVEL = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_hit,
  input  logic              irq_ack,
  input  logic [MASK_W-1:0] cpu_imask,
  output logic              brk_pend,
  output logic              brk_req
);

  localparam logic [MASK_W-1:0] LVL = MASK_W'(BRK_LEVEL);

  logic pend_q, pend_d, pend_en;

  always_comb begin
    pend_en = cyc_hit || irq_ack;
    pend_d  = cyc_hit;  // a new match outranks the acknowledge
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign brk_pend = pend_q;
  assign brk_req  = pend_q && (cpu_imask < LVL);

endmodule

// File: rtl/brk_cycle_watch.sv
module brk_cycle_watch
  import brk_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MASK_W    = 4,
  parameter int BRK_LEVEL = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              bus_vld,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_dma,
  input  logic              bus_data,
  input  logic              bus_wr,
  input  logic [MASK_W-1:0] cpu_imask,
  input  logic              irq_ack,
  output logic              brk_pend,
  output logic              brk_req
);

  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic [ADDR_W-1:0] tgt_q, amask_q;
  brk_cond_t         cond_q;
  logic              cyc_hit;

  brk_cfg_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .tgt_q    (tgt_q),
    .amask_q  (amask_q),
    .cond_q   (cond_q)
  );

  brk_cycle_match #(.ADDR_W(ADDR_W)) match_i (
    .bus_vld (bus_vld),
    .bus_addr(bus_addr),
    .bus_dma (bus_dma),
    .bus_data(bus_data),
    .bus_wr  (bus_wr),
    .tgt     (tgt_q),
    .amask   (amask_q),
    .cond    (cond_q),
    .cyc_hit (cyc_hit)
  );

  brk_accept #(.MASK_W(MASK_W), .BRK_LEVEL(BRK_LEVEL)) acc_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cyc_hit  (cyc_hit),
    .irq_ack  (irq_ack),
    .cpu_imask(cpu_imask),
    .brk_pend (brk_pend),
    .brk_req  (brk_req)
  );

endmodule

// File: rtl/brk_cycle_watch_chk.sv
module brk_cycle_watch_chk
  import brk_pkg::*;
#(
  parameter int MASK_W    = 4,
  parameter int BRK_LEVEL = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_vld,
  input logic              cyc_hit,
  input brk_cond_t         cond_q,
  input logic [MASK_W-1:0] cpu_imask,
  input logic              irq_ack,
  input logic              brk_pend,
  input logic              brk_req
);

  localparam logic [MASK_W-1:0] LVL = MASK_W'(BRK_LEVEL);

  // R8
  hit_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_hit |=> brk_pend);

  // R8
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_pend && !irq_ack) |=> brk_pend);

  // R11
  idle_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!brk_pend && !bus_vld) |=> !brk_pend);

  // R6
  zero_sel_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_hit |-> (cond_q.mst_sel != 2'b00 && cond_q.kind_sel != 2'b00 &&
                 cond_q.dir_sel != 2'b00));

  // R7
  disabled_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_q.en |-> !cyc_hit);

  // R9
  masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_imask >= LVL) |-> !brk_req);

  // R9
  unmasked_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_pend && cpu_imask < LVL) |-> brk_req);

endmodule

bind brk_cycle_watch brk_cycle_watch_chk #(.MASK_W(MASK_W), .BRK_LEVEL(BRK_LEVEL)) chk_i (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .bus_vld  (bus_vld),
  .cyc_hit  (cyc_hit),
  .cond_q   (cond_q),
  .cpu_imask(cpu_imask),
  .irq_ack  (irq_ack),
  .brk_pend (brk_pend),
  .brk_req  (brk_req)
);

// File: tb/brk_cycle_watch_tb_top.sv
`timescale 1ns/1ps
module brk_cycle_watch_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        bus_vld = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_dma = 1'b0, bus_data = 1'b0, bus_wr = 1'b0;
  logic [3:0]  cpu_imask = 4'd0;
  logic        irq_ack = 1'b0;
  logic        brk_pend, brk_req;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  brk_cycle_watch dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .bus_vld(bus_vld), .bus_addr(bus_addr),
    .bus_dma(bus_dma), .bus_data(bus_data), .bus_wr(bus_wr),
    .cpu_imask(cpu_imask), .irq_ack(irq_ack), .brk_pend(brk_pend),
    .brk_req(brk_req)
  );

  typedef struct packed {
    logic [31:0] tgt;
    logic [31:0] msk;
    logic [6:0]  cnd;   // {en, dir, kind, master}
    logic [31:0] adr;
    logic        dma;
    logic        dat;
    logic        wr;
    logic        exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{32'h1000, 32'h0,  7'h7F, 32'h1000, 1'b0, 1'b0, 1'b0, 1'b1}, // R2 exact
    '{32'h1000, 32'h0,  7'h7F, 32'h1010, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 bit4 differs
    '{32'h1000, 32'h10, 7'h7F, 32'h1010, 1'b0, 1'b0, 1'b0, 1'b1}, // R2 bit4 masked
    '{32'h1000, 32'h10, 7'h7F, 32'h1100, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 bit8 unmasked
    '{32'h1000, 32'h0,  7'h7D, 32'h1000, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 cpu only, dma
    '{32'h1000, 32'h0,  7'h7E, 32'h1000, 1'b1, 1'b0, 1'b0, 1'b1}, // R3 dma only, dma
    '{32'h1000, 32'h0,  7'h77, 32'h1000, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 fetch only, data
    '{32'h1000, 32'h0,  7'h7B, 32'h1000, 1'b0, 1'b1, 1'b0, 1'b1}, // R4 data only, data
    '{32'h1000, 32'h0,  7'h5F, 32'h1000, 1'b0, 1'b0, 1'b1, 1'b0}, // R5 read only, write
    '{32'h1000, 32'h0,  7'h6F, 32'h1000, 1'b0, 1'b0, 1'b1, 1'b1}, // R5 write only, write
    '{32'h1000, 32'h0,  7'h7C, 32'h1000, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 master 00
    '{32'h1000, 32'h0,  7'h73, 32'h1000, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 kind 00
    '{32'h1000, 32'h0,  7'h4F, 32'h1000, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 dir 00
    '{32'h1000, 32'h0,  7'h3F, 32'h1000, 1'b0, 1'b0, 1'b0, 1'b0}  // R7 enable 0
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic bus_cyc(input logic [31:0] a, input logic m, input logic k, input logic w);
    @(negedge clk);
    bus_vld = 1'b1; bus_addr = a; bus_dma = m; bus_data = k; bus_wr = w;
    @(negedge clk);
    bus_vld = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state and disabled after reset
    chk("R1 pend after reset", brk_pend, 1'b0);
    chk("R1 req after reset", brk_req, 1'b0);
    bus_cyc(32'h0, 1'b0, 1'b0, 1'b0);
    chk("R1 no break from zero regs", brk_pend, 1'b0);

    // table of vectors
    for (int i = 0; i < NV; i++) begin
      wr_reg(2'd0, VECS[i].tgt);
      wr_reg(2'd1, VECS[i].msk);
      wr_reg(2'd2, {25'd0, VECS[i].cnd});
      bus_cyc(VECS[i].adr, VECS[i].dma, VECS[i].dat, VECS[i].wr);
      chk($sformatf("R2-7 vec%0d pend", i), brk_pend, VECS[i].exp);
      chk($sformatf("R9 vec%0d req", i), brk_req, VECS[i].exp);
      ack();
      chk($sformatf("R8 vec%0d ack clear", i), brk_pend, 1'b0);
    end

    // R11 matching inputs without strobe
    wr_reg(2'd0, 32'h2000);
    wr_reg(2'd1, 32'h0);
    wr_reg(2'd2, 32'h7F);
    @(negedge clk);
    bus_vld = 1'b0; bus_addr = 32'h2000; bus_dma = 0; bus_data = 0; bus_wr = 0;
    repeat (2) @(negedge clk);
    chk("R11 no strobe no break", brk_pend, 1'b0);

    // R8 sticky without ack
    bus_cyc(32'h2000, 1'b0, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    chk("R8 sticky pend", brk_pend, 1'b1);
    ack();
    chk("R8 cleared by ack", brk_pend, 1'b0);

    // R9 held pending at mask 15
    cpu_imask = 4'd15;
    bus_cyc(32'h2000, 1'b0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    chk("R9 pend held at mask15", brk_pend, 1'b1);
    chk("R9 no req at mask15", brk_req, 1'b0);
    cpu_imask = 4'd14;
    #1;
    chk("R9 req at mask14", brk_req, 1'b1);
    ack();
    cpu_imask = 4'd0;
    chk("R9 req gone after ack", brk_req, 1'b0);

    // R10 write coincident with bus cycle uses old target
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'h3000;
    bus_vld = 1'b1; bus_addr = 32'h2000; bus_dma = 0; bus_data = 0; bus_wr = 0;
    @(negedge clk);
    cfg_we = 1'b0; bus_vld = 1'b0;
    chk("R10 old target matched", brk_pend, 1'b1);
    ack();
    bus_cyc(32'h2000, 1'b0, 1'b0, 1'b0);
    chk("R10 old target gone", brk_pend, 1'b0);
    bus_cyc(32'h3000, 1'b0, 1'b0, 1'b0);
    chk("R10 new target matched", brk_pend, 1'b1);
    ack();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule